// File: doc/BRIEF.md
# Delayed Memory Read Tracker

This block sits between a parallel bus target port and an upstream fetch engine. It serves every memory read it accepts as a deferred transaction. On first sight of a request it records the address, the command code and the address parity in one of a small number of queue slots. It answers the requester with a retry. It then sends an upstream fetch request for that slot. The fetch length follows from the command, the data path width and the bus clock rate, and it is cut short so that it never crosses a 4 KB page.

In the default mode the requester keeps repeating the same read. A repeat that finds its slot still waiting gets another retry. A repeat that finds the data returned receives the data and releases the slot. In split mode the requester is told at once that the read will complete later. Returned upstream data is then pushed straight out as a split completion that carries the slot tag, and the slot is freed without any repeat.

Top module: `dly_rd_tracker`

## Requirements
- R1: After reset every slot is empty, and neither a response, a fetch request nor a split completion is presented.
- R2: A read (command 4'h6 plain, 4'hE line, 4'hC multiple) that matches no slot, seen while a slot is free, takes the lowest-numbered free slot. In default mode it is answered one cycle later with rsp_code 0 (retry) and that slot's tag, and a fetch request for that tag and address appears in the same cycle.
- R3: Before clamping, the fetch length in bytes is 4 for a plain read and 64 for a line read. A multiple read gets 128 when req_wide is 0 and 256 when req_wide is 1, and this multiple-read length doubles when req_fast is 1.
- R4: The fetch length never exceeds 4096 minus the low 12 address bits. When the unclamped length would exceed that room, the length equals the room.
- R5: In default mode, a repeat of a read whose slot still waits for data is answered with retry and that slot's tag. It allocates no slot and starts no new fetch.
- R6: A repeat matches a slot only when address, command and parity are all equal. A request that differs in parity alone takes a new slot.
- R7: A repeat that matches a slot holding returned data is answered with rsp_code 1 (data), the slot's tag and the returned data word. The slot becomes free for the next allocation.
- R8: A new read that arrives while all slots are occupied is answered with retry. It allocates nothing and starts no fetch.
- R9: In split mode a new read is answered with rsp_code 2 (split) and its slot tag. The upstream completion for that slot produces sc_valid one cycle later, with the tag and the data, and the slot is freed.
- R10: A command other than the three read codes produces no response and no allocation.
- R11: An upstream completion whose tag names a slot that is not waiting for issued fetch data has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| split_mode | input | 1 | 1 selects split completion handling for new requests |
| req_valid | input | 1 | A bus read request is presented this cycle |
| req_addr | input | 32 | Request byte address |
| req_cmd | input | 4 | Request command code |
| req_par | input | 1 | Address parity bit seen with the request |
| req_wide | input | 1 | Request uses the 64-bit data path |
| req_fast | input | 1 | Bus runs at the higher clock rate |
| rsp_valid | output | 1 | Response to a request is valid |
| rsp_code | output | 2 | 0 retry, 1 data, 2 split |
| rsp_tag | output | 2 | Slot the response refers to |
| rsp_data | output | 32 | Returned data word for a data response |
| fetch_valid | output | 1 | Upstream fetch request is valid |
| fetch_ready | input | 1 | Upstream accepts the fetch request |
| fetch_tag | output | 2 | Slot of the fetch |
| fetch_addr | output | 32 | Fetch start address |
| fetch_len | output | 13 | Fetch length in bytes |
| cpl_valid | input | 1 | Upstream data returned |
| cpl_tag | input | 2 | Slot the returned data belongs to |
| cpl_data | input | 32 | Returned data word |
| sc_valid | output | 1 | Split completion is valid |
| sc_tag | output | 2 | Slot of the split completion |
| sc_data | output | 32 | Split completion data |

## Verification
The bench drives reads just below a page end, where a design without the clamp would ask for data from the next page and a clamp off by one would lose or add a byte. It also sends a request that differs from a waiting one only in parity. A sloppy comparator would then return another read's data instead of taking a new slot. It fills every slot and checks that an overflow request neither overwrites a slot nor starts a fetch. It then repeats a completed read twice, so a design that keeps the slot after delivering its data would hand the same data out again. Completions aimed at idle slots, and split-mode returns, catch designs that store stray data or wait for a repeat that will never come.

// File: rtl/dly_rd_pkg.sv
package dly_rd_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 13;
    localparam int CMD_W  = 4;

    localparam logic [CMD_W-1:0] CMD_RD_PLAIN = 4'h6;
    localparam logic [CMD_W-1:0] CMD_RD_LINE  = 4'hE;
    localparam logic [CMD_W-1:0] CMD_RD_MULTI = 4'hC;

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_DONE  = 2'd2
    } slot_st_e;

    typedef enum logic [1:0] {
        ANS_RETRY = 2'd0,
        ANS_DATA  = 2'd1,
        ANS_SPLIT = 2'd2
    } ans_e;

    typedef struct packed {
        slot_st_e            st;
        logic [ADDR_W-1:0]   addr;
        logic [CMD_W-1:0]    cmd;
        logic                par;
        logic                split;
        logic                issued;
        logic [LEN_W-1:0]    len;
        logic [DATA_W-1:0]   data;
    } slot_t;
endpackage

// File: rtl/dly_rd_len.sv
module dly_rd_len
    import dly_rd_pkg::*;
#(
    parameter int PAGE_BYTES = 4096,
    parameter int LINE_BYTES = 64
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic              wide_i,
    input  logic              fast_i,
    output logic              is_read_o,
    output logic [LEN_W-1:0]  len_o
);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic [LEN_W-1:0] base;
    logic [LEN_W-1:0] room;

    always_comb begin
        is_read_o = 1'b1;
        base      = '0;
        case (cmd_i)
            CMD_RD_PLAIN: base = LEN_W'(4);
            CMD_RD_LINE:  base = LEN_W'(LINE_BYTES);
            CMD_RD_MULTI: begin
                base = wide_i ? LEN_W'(LINE_BYTES * 4) : LEN_W'(LINE_BYTES * 2);
                if (fast_i) base = base << 1;
            end
            default: is_read_o = 1'b0;
        endcase
        room  = LEN_W'(PAGE_BYTES) - LEN_W'(addr_i[OFF_W-1:0]);
        len_o = (base > room) ? room : base;
    end

    // R4: a read never reaches past its page
    always_comb begin
        if (is_read_o) begin
            a_r4_page_clamp: assert (len_o <= room && len_o != '0);
        end
    end
endmodule

// File: rtl/dly_rd_pick.sv
module dly_rd_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dly_rd_tracker.sv
module dly_rd_tracker
    import dly_rd_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int PAGE_BYTES = 4096,
    parameter int LINE_BYTES = 64,
    localparam int TAG_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              split_mode,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic              req_par,
    input  logic              req_wide,
    input  logic              req_fast,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fetch_valid,
    input  logic              fetch_ready,
    output logic [TAG_W-1:0]  fetch_tag,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [LEN_W-1:0]  fetch_len,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [DATA_W-1:0] cpl_data,
    output logic              sc_valid,
    output logic [TAG_W-1:0]  sc_tag,
    output logic [DATA_W-1:0] sc_data
);
    typedef struct packed {
        slot_t [DEPTH-1:0]  slot;
        logic               rsp_valid;
        logic [1:0]         rsp_code;
        logic [TAG_W-1:0]   rsp_tag;
        logic [DATA_W-1:0]  rsp_data;
        logic               sc_valid;
        logic [TAG_W-1:0]   sc_tag;
        logic [DATA_W-1:0]  sc_data;
    } state_t;

    state_t st_d, st_q;

    logic [DEPTH-1:0] free_vec, hit_vec, send_vec, occ_q;
    logic             free_any, hit_any, send_any;
    logic [TAG_W-1:0] free_idx, hit_idx, send_idx;
    logic             is_read;
    logic [LEN_W-1:0] new_len;

    dly_rd_len #(.PAGE_BYTES(PAGE_BYTES), .LINE_BYTES(LINE_BYTES)) u_len (
        .addr_i(req_addr), .cmd_i(req_cmd), .wide_i(req_wide), .fast_i(req_fast),
        .is_read_o(is_read), .len_o(new_len)
    );

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            free_vec[i] = (st_q.slot[i].st == SLOT_EMPTY);
            send_vec[i] = (st_q.slot[i].st == SLOT_WAIT) && !st_q.slot[i].issued;
            hit_vec[i]  = (st_q.slot[i].st != SLOT_EMPTY) && !st_q.slot[i].split
                          && (st_q.slot[i].addr == req_addr)
                          && (st_q.slot[i].cmd  == req_cmd)
                          && (st_q.slot[i].par  == req_par);
        end
        occ_q = ~free_vec;
    end

    dly_rd_pick #(.N(DEPTH), .IW(TAG_W)) u_pick_free (
        .vec_i(free_vec), .found_o(free_any), .idx_o(free_idx));
    dly_rd_pick #(.N(DEPTH), .IW(TAG_W)) u_pick_hit (
        .vec_i(hit_vec), .found_o(hit_any), .idx_o(hit_idx));
    dly_rd_pick #(.N(DEPTH), .IW(TAG_W)) u_pick_send (
        .vec_i(send_vec), .found_o(send_any), .idx_o(send_idx));

    assign fetch_valid = send_any;
    assign fetch_tag   = send_idx;
    assign fetch_addr  = st_q.slot[send_idx].addr;
    assign fetch_len   = st_q.slot[send_idx].len;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.sc_valid  = 1'b0;

        if (send_any && fetch_ready) begin
            st_d.slot[send_idx].issued = 1'b1;
        end

        if (cpl_valid && (int'(cpl_tag) < DEPTH)
            && st_q.slot[cpl_tag].st == SLOT_WAIT && st_q.slot[cpl_tag].issued) begin
            if (st_q.slot[cpl_tag].split) begin
                st_d.slot[cpl_tag].st = SLOT_EMPTY;
                st_d.sc_valid         = 1'b1;
                st_d.sc_tag           = cpl_tag;
                st_d.sc_data          = cpl_data;
            end else begin
                st_d.slot[cpl_tag].st   = SLOT_DONE;
                st_d.slot[cpl_tag].data = cpl_data;
            end
        end

        if (req_valid && is_read) begin
            st_d.rsp_valid = 1'b1;
            st_d.rsp_code  = ANS_RETRY;
            st_d.rsp_tag   = '0;
            if (!split_mode && hit_any) begin
                st_d.rsp_tag = hit_idx;
                if (st_q.slot[hit_idx].st == SLOT_DONE) begin
                    st_d.rsp_code            = ANS_DATA;
                    st_d.rsp_data            = st_q.slot[hit_idx].data;
                    st_d.slot[hit_idx].st    = SLOT_EMPTY;
                end
            end else if (free_any) begin
                st_d.slot[free_idx] = '{st: SLOT_WAIT, addr: req_addr, cmd: req_cmd,
                                        par: req_par, split: split_mode, issued: 1'b0,
                                        len: new_len, data: '0};
                st_d.rsp_tag  = free_idx;
                st_d.rsp_code = split_mode ? ANS_SPLIT : ANS_RETRY;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_code  = st_q.rsp_code;
    assign rsp_tag   = st_q.rsp_tag;
    assign rsp_data  = st_q.rsp_data;
    assign sc_valid  = st_q.sc_valid;
    assign sc_tag    = st_q.sc_tag;
    assign sc_data   = st_q.sc_data;

    // R2: at most one slot is taken per cycle
    a_r2_one_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(occ_q) <= $past($countones(occ_q)) + 1);

    // R8: a read seen with every slot busy and no match adds no slot
    a_r8_full_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_read && (&occ_q) && !hit_any) |=>
            $countones(occ_q) <= $past($countones(occ_q)));

    // R7: a data answer leaves its slot empty
    a_r7_data_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == ANS_DATA) |-> !occ_q[rsp_tag]);

    // R9: a return for a waiting split slot is pushed out next cycle
    a_r9_split_push: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && st_q.slot[cpl_tag].st == SLOT_WAIT && st_q.slot[cpl_tag].issued
         && st_q.slot[cpl_tag].split) |=> (sc_valid && sc_tag == $past(cpl_tag)));

    // R11: a return for an idle slot produces no split completion
    a_r11_stray_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && st_q.slot[cpl_tag].st == SLOT_EMPTY) |=> !sc_valid);
endmodule

// File: tb/sim_dly_rd_tracker.sv
`timescale 1ns/1ps
module sim_dly_rd_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        split_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_cmd = '0;
    logic        req_par = 1'b0, req_wide = 1'b0, req_fast = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [1:0]  rsp_tag;
    logic [31:0] rsp_data;
    logic        fetch_valid;
    logic        fetch_ready = 1'b1;
    logic [1:0]  fetch_tag;
    logic [31:0] fetch_addr;
    logic [12:0] fetch_len;
    logic        cpl_valid = 1'b0;
    logic [1:0]  cpl_tag = '0;
    logic [31:0] cpl_data = '0;
    logic        sc_valid;
    logic [1:0]  sc_tag;
    logic [31:0] sc_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dly_rd_tracker u0 (
        .clk(clk), .rst_n(rst_n), .split_mode(split_mode),
        .req_valid(req_valid), .req_addr(req_addr), .req_cmd(req_cmd),
        .req_par(req_par), .req_wide(req_wide), .req_fast(req_fast),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_tag(fetch_tag),
        .fetch_addr(fetch_addr), .fetch_len(fetch_len),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data),
        .sc_valid(sc_valid), .sc_tag(sc_tag), .sc_data(sc_data)
    );

    function automatic int exp_len(logic [31:0] a, logic [3:0] c, logic w, logic f);
        int base;
        int room;
        case (c)
            4'h6: base = 4;
            4'hE: base = 64;
            default: begin
                base = w ? 256 : 128;
                if (f) base = base * 2;
            end
        endcase
        room = 4096 - int'(a[11:0]);
        return (base > room) ? room : base;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(logic [31:0] a, logic [3:0] c, logic p, logic w, logic f);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_cmd = c; req_par = p; req_wide = w; req_fast = f;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ret(logic [1:0] t, logic [31:0] d);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_tag = t; cpl_data = d;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; split_mode = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, dv;
        logic [3:0]  c;
        logic        w, f;
        int          dummy;
        dummy = $urandom(32'h5eed_0042);
        do_reset();
        // R1
        chk(!rsp_valid && !fetch_valid && !sc_valid, "R1", {rsp_valid, fetch_valid, sc_valid}, 0);

        // R10: non-read command
        send(32'h0000_1000, 4'h7, 1'b0, 1'b0, 1'b0);
        chk(!rsp_valid && !fetch_valid, "R10", {rsp_valid, fetch_valid}, 0);

        // R2, R6, R5, R8, R7
        send(32'h0000_2000, 4'hE, 1'b0, 1'b0, 1'b0);
        chk(rsp_valid && rsp_code == 0 && rsp_tag == 0, "R2", {rsp_valid, rsp_code, rsp_tag}, 3'b100);
        chk(fetch_valid && fetch_tag == 0 && fetch_addr == 32'h2000 && fetch_len == 64,
            "R2", fetch_len, 64);
        send(32'h0000_2000, 4'hE, 1'b1, 1'b0, 1'b0);
        chk(rsp_tag == 1 && fetch_valid && fetch_tag == 1, "R6", {rsp_tag, fetch_tag}, 4'b0101);
        send(32'h0000_3000, 4'h6, 1'b0, 1'b0, 1'b0);
        send(32'h0000_4000, 4'h6, 1'b0, 1'b0, 1'b0);
        chk(rsp_tag == 3, "R2", rsp_tag, 3);
        send(32'h0000_5000, 4'h6, 1'b0, 1'b0, 1'b0);
        chk(rsp_valid && rsp_code == 0 && !fetch_valid, "R8", {rsp_code, fetch_valid}, 0);
        send(32'h0000_2000, 4'hE, 1'b0, 1'b0, 1'b0);
        chk(rsp_code == 0 && rsp_tag == 0 && !fetch_valid, "R5", {rsp_code, rsp_tag, fetch_valid}, 0);
        ret(2'd1, 32'hCAFE_0001);
        chk(!sc_valid, "R9", sc_valid, 0);
        send(32'h0000_2000, 4'hE, 1'b1, 1'b0, 1'b0);
        chk(rsp_code == 1 && rsp_tag == 1 && rsp_data == 32'hCAFE_0001, "R7", rsp_data, 32'hCAFE_0001);
        send(32'h0000_2000, 4'hE, 1'b1, 1'b0, 1'b0);
        chk(rsp_code == 0 && rsp_tag == 1 && fetch_valid && fetch_tag == 1, "R7",
            {rsp_code, rsp_tag}, 2'b01);

        // R11: stray return on an empty slot
        do_reset();
        ret(2'd0, 32'hDEAD_BEEF);
        chk(!sc_valid, "R11", sc_valid, 0);
        send(32'h0000_6000, 4'h6, 1'b0, 1'b0, 1'b0);
        chk(rsp_code == 0 && rsp_tag == 0 && fetch_valid, "R11", rsp_code, 0);
        send(32'h0000_6000, 4'h6, 1'b0, 1'b0, 1'b0);
        chk(rsp_code == 0, "R11", rsp_code, 0);

        // R4 directed page-end cases
        do_reset();
        send(32'h0000_7FC0, 4'hC, 1'b0, 1'b1, 1'b0);
        chk(fetch_len == 64, "R4", fetch_len, 64);
        send(32'h0000_8FFC, 4'h6, 1'b0, 1'b0, 1'b0);
        chk(fetch_len == 4, "R4", fetch_len, 4);
        send(32'h0000_9FF0, 4'hE, 1'b0, 1'b0, 1'b0);
        chk(fetch_len == 16, "R4", fetch_len, 16);

        // R9 split mode
        do_reset();
        split_mode = 1'b1;
        send(32'h0000_A000, 4'hC, 1'b0, 1'b0, 1'b1);
        chk(rsp_code == 2 && rsp_tag == 0 && fetch_valid && fetch_len == 256, "R9", rsp_code, 2);
        ret(2'd0, 32'h1234_5678);
        chk(sc_valid && sc_tag == 0 && sc_data == 32'h1234_5678, "R9", sc_data, 32'h1234_5678);
        send(32'h0000_B000, 4'h6, 1'b0, 1'b0, 1'b0);
        chk(rsp_code == 2 && rsp_tag == 0, "R9", rsp_tag, 0);

        // random round trips, R3 and R4
        do_reset();
        for (int n = 0; n < 60; n++) begin
            a = {$urandom} & 32'hFFFF_FFFC;
            if (n % 4 == 0) a[11:0] = 12'hF00 | (a[11:0] & 12'h0FC);
            case ($urandom % 3)
                0: c = 4'h6;
                1: c = 4'hE;
                default: c = 4'hC;
            endcase
            w = 1'($urandom); f = 1'($urandom); dv = $urandom;
            send(a, c, 1'b0, w, f);
            chk(fetch_valid && fetch_addr == a && int'(fetch_len) == exp_len(a, c, w, f),
                "R3", fetch_len, exp_len(a, c, w, f));
            ret(rsp_tag, dv);
            send(a, c, 1'b0, w, f);
            chk(rsp_code == 1 && rsp_data == dv, "R7", rsp_data, dv);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule